// File: doc/BRIEF.md
# Paged Program Counter Call/Return Unit

This block holds the program counter of an 8051-style core running in a 22-bit paged code mode. The counter is split into a 16-bit in-page offset and an 8-bit page byte. The page byte is a plain storage register. It changes only when a long jump, a call or a return writes it, and never through a carry out of the offset. The unit decodes the absolute and long calls, the long jump, the return, the indirect jump through the data pointer and an interrupt-entry request. It then runs the multi-cycle stack sequences that save or restore a three-byte return address through a byte-wide stack memory port.

The surrounding core presents the bytes of an instruction together with a one-cycle valid strobe. It supplies the address-page byte that calls and long jumps copy into the page register, and it pulses a step input for ordinary sequential fetch. The unit also forms a 24-bit code-fetch address for table reads and indirect jumps. The page part of that address comes only from the current page byte, and the low 16 bits are the data pointer plus the accumulator. While a stack sequence runs, a busy flag is high and all new requests are dropped.

Top module: `pgpc_unit`

## Requirements
- R1: When `pc_inc` steps the offset from FFFFh to 0000h, the page byte (`pc_full[23:16]`) keeps its value.
- R2: Opcode 02h (long jump) takes `op_b1` as offset bits 15..8 and `op_b2` as bits 7..0. It copies `ap_page` into the page byte, completes in the accept cycle and never raises `busy`.
- R3: An absolute call is any first byte whose bits 4..0 are 10001b; bits 7..5 of that byte give target bits 10..8, and `op_b1` gives bits 7..0. The unit adds 2 to the offset and saves that value. Offset bits 10..0 then take the target while bits 15..11 keep the advanced value, and the page byte takes `ap_page`.
- R4: Opcode 12h (long call) adds 3 to the offset and saves that value. It then loads the offset with {`op_b1`,`op_b2`} and the page byte with `ap_page`.
- R5: A save writes three bytes at SP+1, SP+2 and SP+3 in that order: offset low, offset high, page byte. Each write increments the 8-bit SP first, and SP wraps modulo 256.
- R6: Opcode 22h (return) reads the page byte at SP, the offset high byte at SP-1 and the offset low byte at SP-2, decrementing SP after each read, with a net change of -3. Read data is taken in the same cycle as the strobe.
- R7: Counting the accept cycle, the absolute call takes 4 cycles, and the long call, the return and interrupt entry take 5 cycles each.
- R8: `irq_req` saves the current offset without advancing it. It loads the offset from `irq_vec` and leaves the page byte unchanged. When `op_valid` is asserted in the same cycle, the interrupt wins and the instruction is dropped.
- R9: While `busy` is high, `op_valid`, `irq_req`, `pc_inc` and changes of `ap_page` have no effect on the outcome of the sequence.
- R10: `code_addr` equals {page byte, (`dptr`+`acc`) mod 65536}. Opcode 73h loads the offset with that 16-bit sum and leaves the page byte unchanged.
- R11: After reset the offset and the page byte are 0, SP is 07h and `busy` is low.
- R12: Any other opcode leaves the PC and SP unchanged. In an idle cycle with no request, `pc_inc` adds 1 to the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction bytes are valid this cycle |
| op_b0 | input | 8 | Opcode byte |
| op_b1 | input | 8 | Second instruction byte |
| op_b2 | input | 8 | Third instruction byte |
| irq_req | input | 1 | Interrupt entry request |
| irq_vec | input | 16 | In-page vector for interrupt entry |
| pc_inc | input | 1 | Sequential fetch step of the offset |
| ap_page | input | 8 | Address-page byte copied on calls and long jumps |
| acc | input | 8 | Accumulator value for indexed addressing |
| dptr | input | 16 | Selected data pointer, low 16 bits |
| busy | output | 1 | A stack sequence is running |
| pc_full | output | 24 | Page byte and in-page offset |
| sp_val | output | 8 | Stack pointer |
| code_addr | output | 24 | Indexed code-fetch address |
| stk_en | output | 1 | Stack access strobe |
| stk_we | output | 1 | Stack access is a write |
| stk_addr | output | 8 | Stack byte address |
| stk_wdata | output | 8 | Stack write data |
| stk_rdata | input | 8 | Stack read data, same cycle |

## Verification
An interrupt request and an instruction can be accepted in the same idle cycle. The bench provokes this by raising `irq_req` together with a long-call opcode. It judges the result by the stack image and final PC: the unadvanced offset and the old page must be saved, the vector loaded and the page byte kept, with no trace of the call target or of `ap_page`. The bench also overlaps new requests, fetch steps and a changed `ap_page` with a running sequence. It expects the final state to be exactly what the first request alone would produce.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 16;
    localparam int PAGE_W = 8;
    localparam int SP_W   = 8;
    localparam int SHORT_W = 11;

    localparam logic [BYTE_W-1:0] OPC_LJMP = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_LCALL = 8'h12;
    localparam logic [BYTE_W-1:0] OPC_RET = 8'h22;
    localparam logic [BYTE_W-1:0] OPC_JIND = 8'h73;
    localparam logic [4:0] SHORT_CALL_TAG = 5'b10001;

    typedef enum logic [2:0] {
        K_NONE, K_ACALL, K_LCALL, K_LJMP, K_RET, K_JIND, K_IRQ
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_OPND, S_PUSH_LO, S_PUSH_HI, S_PUSH_PG,
        S_POP_PG, S_POP_HI, S_POP_LO
    } seq_state_e;

    typedef struct packed {
        op_kind_e           kind;
        logic [OFS_W-1:0]   target;
    } dec_req_t;

    function automatic op_kind_e classify(input logic [BYTE_W-1:0] opc);
        op_kind_e k;
        k = K_NONE;
        if (opc[4:0] == SHORT_CALL_TAG) k = K_ACALL;
        else if (opc == OPC_LCALL)      k = K_LCALL;
        else if (opc == OPC_LJMP)       k = K_LJMP;
        else if (opc == OPC_RET)        k = K_RET;
        else if (opc == OPC_JIND)       k = K_JIND;
        return k;
    endfunction
endpackage

// File: rtl/pgpc_decode.sv
module pgpc_decode
    import pgpc_pkg::*;
(
    input  logic                op_valid,
    input  logic [BYTE_W-1:0]   op_b0,
    input  logic [BYTE_W-1:0]   op_b1,
    input  logic [BYTE_W-1:0]   op_b2,
    input  logic                irq_req,
    input  logic [OFS_W-1:0]    irq_vec,
    output dec_req_t            req
);
    always_comb begin
        req.kind   = K_NONE;
        req.target = '0;
        if (irq_req) begin
            req.kind   = K_IRQ;
            req.target = irq_vec;
        end else if (op_valid) begin
            req.kind = classify(op_b0);
            unique case (req.kind)
                K_ACALL: req.target = {{(OFS_W-SHORT_W){1'b0}}, op_b0[7:5], op_b1};
                K_LCALL, K_LJMP: req.target = {op_b1, op_b2};
                default: req.target = '0;
            endcase
        end
    end
endmodule

// File: rtl/pgpc_codeaddr.sv
module pgpc_codeaddr
    import pgpc_pkg::*;
(
    input  logic [PAGE_W-1:0]        page,
    input  logic [OFS_W-1:0]         dptr,
    input  logic [BYTE_W-1:0]        acc,
    output logic [PAGE_W+OFS_W-1:0]  addr
);
    logic [OFS_W-1:0] sum;
    always_comb begin
        sum  = dptr + {{(OFS_W-BYTE_W){1'b0}}, acc};
        addr = {page, sum};
    end
endmodule

// File: rtl/pgpc_seq.sv
module pgpc_seq
    import pgpc_pkg::*;
#(
    parameter logic [SP_W-1:0] RESET_SP = 8'h07
) (
    input  logic                clk,
    input  logic                rst,
    input  dec_req_t            req,
    input  logic [PAGE_W-1:0]   ap_page,
    input  logic [OFS_W-1:0]    jind_addr,
    input  logic                pc_inc,
    input  logic [BYTE_W-1:0]   stk_rdata,
    output logic [OFS_W-1:0]    pc_ofs,
    output logic [PAGE_W-1:0]   pc_pg,
    output logic [SP_W-1:0]     sp,
    output logic                busy,
    output logic                stk_en,
    output logic                stk_we,
    output logic [SP_W-1:0]     stk_addr,
    output logic [BYTE_W-1:0]   stk_wdata
);
    seq_state_e         state;
    op_kind_e           kind_q;
    logic [OFS_W-1:0]   tgt_q;
    logic [PAGE_W-1:0]  ap_q;
    logic               ldpg_q;
    logic               accept;
    logic [OFS_W-1:0]   ofs_plus2;

    assign busy      = (state != S_IDLE);
    assign accept    = (state == S_IDLE) && (req.kind != K_NONE);
    assign ofs_plus2 = pc_ofs + 16'd2;

    always_comb begin
        stk_en    = 1'b0;
        stk_we    = 1'b0;
        stk_addr  = sp;
        stk_wdata = '0;
        unique case (state)
            S_PUSH_LO: begin stk_en = 1'b1; stk_we = 1'b1; stk_addr = sp + 8'd1; stk_wdata = pc_ofs[7:0];  end
            S_PUSH_HI: begin stk_en = 1'b1; stk_we = 1'b1; stk_addr = sp + 8'd1; stk_wdata = pc_ofs[15:8]; end
            S_PUSH_PG: begin stk_en = 1'b1; stk_we = 1'b1; stk_addr = sp + 8'd1; stk_wdata = pc_pg;        end
            S_POP_PG, S_POP_HI, S_POP_LO: stk_en = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            kind_q <= K_NONE;
            tgt_q  <= '0;
            ap_q   <= '0;
            ldpg_q <= 1'b0;
            pc_ofs <= '0;
            pc_pg  <= '0;
            sp     <= RESET_SP;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        kind_q <= req.kind;
                        ap_q   <= ap_page;
                        unique case (req.kind)
                            K_ACALL: begin
                                pc_ofs <= ofs_plus2;
                                tgt_q  <= {ofs_plus2[OFS_W-1:SHORT_W], req.target[SHORT_W-1:0]};
                                ldpg_q <= 1'b1;
                                state  <= S_PUSH_LO;
                            end
                            K_LCALL: begin
                                pc_ofs <= pc_ofs + 16'd3;
                                tgt_q  <= req.target;
                                ldpg_q <= 1'b1;
                                state  <= S_OPND;
                            end
                            K_IRQ: begin
                                tgt_q  <= req.target;
                                ldpg_q <= 1'b0;
                                state  <= S_OPND;
                            end
                            K_RET: state <= S_OPND;
                            K_LJMP: begin
                                pc_ofs <= req.target;
                                pc_pg  <= ap_page;
                            end
                            K_JIND: pc_ofs <= jind_addr;
                            default: ;
                        endcase
                    end else if (pc_inc) begin
                        pc_ofs <= pc_ofs + 16'd1;
                    end
                end
                S_OPND:    state <= (kind_q == K_RET) ? S_POP_PG : S_PUSH_LO;
                S_PUSH_LO: begin sp <= sp + 8'd1; state <= S_PUSH_HI; end
                S_PUSH_HI: begin sp <= sp + 8'd1; state <= S_PUSH_PG; end
                S_PUSH_PG: begin
                    sp     <= sp + 8'd1;
                    pc_ofs <= tgt_q;
                    if (ldpg_q) pc_pg <= ap_q;
                    state  <= S_IDLE;
                end
                S_POP_PG: begin pc_pg <= stk_rdata;        sp <= sp - 8'd1; state <= S_POP_HI; end
                S_POP_HI: begin pc_ofs[15:8] <= stk_rdata; sp <= sp - 8'd1; state <= S_POP_LO; end
                S_POP_LO: begin pc_ofs[7:0] <= stk_rdata;  sp <= sp - 8'd1; state <= S_IDLE;   end
                default:  state <= S_IDLE;
            endcase
        end
    end

    assert_page_no_carry_R1: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && req.kind == K_NONE && pc_inc) |=> (pc_pg == $past(pc_pg)));

    assert_push_sp_up_R5: assert property (@(posedge clk) disable iff (rst)
        (stk_en && stk_we) |=> (sp == $past(sp) + 8'd1));

    assert_pop_sp_down_R6: assert property (@(posedge clk) disable iff (rst)
        (stk_en && !stk_we) |=> (sp == $past(sp) - 8'd1));

    assert_min_length_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    assert_pc_held_R9: assert property (@(posedge clk) disable iff (rst)
        (state == S_OPND || state == S_PUSH_LO || state == S_PUSH_HI) |=> $stable(pc_ofs) && $stable(pc_pg));
endmodule

// File: rtl/pgpc_unit.sv
module pgpc_unit
    import pgpc_pkg::*;
#(
    parameter logic [7:0] RESET_SP = 8'h07
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [7:0]   op_b0,
    input  logic [7:0]   op_b1,
    input  logic [7:0]   op_b2,
    input  logic         irq_req,
    input  logic [15:0]  irq_vec,
    input  logic         pc_inc,
    input  logic [7:0]   ap_page,
    input  logic [7:0]   acc,
    input  logic [15:0]  dptr,
    output logic         busy,
    output logic [23:0]  pc_full,
    output logic [7:0]   sp_val,
    output logic [23:0]  code_addr,
    output logic         stk_en,
    output logic         stk_we,
    output logic [7:0]   stk_addr,
    output logic [7:0]   stk_wdata,
    input  logic [7:0]   stk_rdata
);
    dec_req_t           req;
    logic [OFS_W-1:0]   pc_ofs;
    logic [PAGE_W-1:0]  pc_pg;

    pgpc_decode u_dec (
        .op_valid (op_valid),
        .op_b0    (op_b0),
        .op_b1    (op_b1),
        .op_b2    (op_b2),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .req      (req)
    );

    pgpc_codeaddr u_cadr (
        .page (pc_pg),
        .dptr (dptr),
        .acc  (acc),
        .addr (code_addr)
    );

    pgpc_seq #(.RESET_SP(RESET_SP)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .ap_page   (ap_page),
        .jind_addr (code_addr[OFS_W-1:0]),
        .pc_inc    (pc_inc),
        .stk_rdata (stk_rdata),
        .pc_ofs    (pc_ofs),
        .pc_pg     (pc_pg),
        .sp        (sp_val),
        .busy      (busy),
        .stk_en    (stk_en),
        .stk_we    (stk_we),
        .stk_addr  (stk_addr),
        .stk_wdata (stk_wdata)
    );

    assign pc_full = {pc_pg, pc_ofs};

    assert_code_page_R10: assert property (@(posedge clk) disable iff (rst)
        code_addr[23:16] == pc_full[23:16]);
endmodule

// File: tb/pgpc_unit_tb.sv
`timescale 1ns/1ps
module pgpc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [7:0]  op_b0 = '0, op_b1 = '0, op_b2 = '0;
    logic        irq_req = 1'b0;
    logic [15:0] irq_vec = '0;
    logic        pc_inc = 1'b0;
    logic [7:0]  ap_page = '0;
    logic [7:0]  acc = '0;
    logic [15:0] dptr = '0;
    logic        busy;
    logic [23:0] pc_full, code_addr;
    logic [7:0]  sp_val, stk_addr, stk_wdata, stk_rdata;
    logic        stk_en, stk_we;

    logic [7:0]  mem [0:255];
    logic [15:0] m_pc;
    logic [7:0]  m_pg, m_sp;
    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    pgpc_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_b0(op_b0), .op_b1(op_b1),
        .op_b2(op_b2), .irq_req(irq_req), .irq_vec(irq_vec), .pc_inc(pc_inc),
        .ap_page(ap_page), .acc(acc), .dptr(dptr), .busy(busy), .pc_full(pc_full),
        .sp_val(sp_val), .code_addr(code_addr), .stk_en(stk_en), .stk_we(stk_we),
        .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata)
    );

    assign stk_rdata = mem[stk_addr];
    always @(posedge clk) if (stk_en && stk_we) mem[stk_addr] <= stk_wdata;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, "pc", {8'h0, pc_full}, {8'h0, m_pg, m_pc});
        chk(req, "sp", {24'h0, sp_val}, {24'h0, m_sp});
    endtask

    task automatic run(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input logic opv, input logic irq, input logic [15:0] vec, output int n);
        @(posedge clk); #1;
        op_valid = opv; op_b0 = b0; op_b1 = b1; op_b2 = b2; irq_req = irq; irq_vec = vec;
        @(posedge clk); #1;
        op_valid = 1'b0; irq_req = 1'b0;
        n = 1;
        while (busy && n < 40) begin @(posedge clk); #1; n++; end
    endtask

    task automatic chk_pushed(input string req, input logic [15:0] ret, input logic [7:0] pg);
        logic [7:0] a1, a2, a3;
        a1 = m_sp + 8'd1; a2 = m_sp + 8'd2; a3 = m_sp + 8'd3;
        chk(req, "push lo", {24'h0, mem[a1]}, {24'h0, ret[7:0]});
        chk(req, "push hi", {24'h0, mem[a2]}, {24'h0, ret[15:8]});
        chk(req, "push pg", {24'h0, mem[a3]}, {24'h0, pg});
        m_sp = a3;
    endtask

    task automatic t_ljmp(input logic [15:0] a, input logic [7:0] ap);
        int n;
        ap_page = ap;
        run(8'h02, a[15:8], a[7:0], 1'b1, 1'b0, 16'h0, n);
        chk("R2", "ljmp cycles", n, 1);
        m_pc = a; m_pg = ap;
        chk_state("R2");
    endtask

    task automatic t_acall(input logic [10:0] a, input logic [7:0] ap);
        int n;
        logic [15:0] ret;
        ret = m_pc + 16'd2;
        ap_page = ap;
        run({a[10:8], 5'b10001}, a[7:0], 8'h5C, 1'b1, 1'b0, 16'h0, n);
        chk("R7", "acall cycles", n, 4);
        chk_pushed("R5", ret, m_pg);
        m_pc = {ret[15:11], a}; m_pg = ap;
        chk_state("R3");
    endtask

    task automatic t_lcall(input logic [15:0] a, input logic [7:0] ap);
        int n;
        logic [15:0] ret;
        ret = m_pc + 16'd3;
        ap_page = ap;
        run(8'h12, a[15:8], a[7:0], 1'b1, 1'b0, 16'h0, n);
        chk("R7", "lcall cycles", n, 5);
        chk_pushed("R5", ret, m_pg);
        m_pc = a; m_pg = ap;
        chk_state("R4");
    endtask

    task automatic t_irq(input logic [15:0] vec, input logic with_op);
        int n;
        ap_page = 8'hE7;
        run(8'h12, 8'hBE, 8'hEF, with_op, 1'b1, vec, n);
        chk("R7", "irq cycles", n, 5);
        chk_pushed("R8", m_pc, m_pg);
        m_pc = vec;
        chk_state("R8");
    endtask

    task automatic t_ret();
        int n;
        logic [7:0] a0, a1, a2;
        a0 = m_sp; a1 = m_sp - 8'd1; a2 = m_sp - 8'd2;
        run(8'h22, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0, n);
        chk("R7", "ret cycles", n, 5);
        m_pg = mem[a0]; m_pc = {mem[a1], mem[a2]}; m_sp = m_sp - 8'd3;
        chk_state("R6");
    endtask

    task automatic t_ignored(input logic [7:0] opc);
        int n;
        run(opc, 8'h11, 8'h22, 1'b1, 1'b0, 16'h0, n);
        chk("R12", "ignored cycles", n, 1);
        chk_state("R12");
    endtask

    task automatic t_step();
        @(posedge clk); #1 pc_inc = 1'b1;
        @(posedge clk); #1 pc_inc = 1'b0;
        m_pc = m_pc + 16'd1;
    endtask

    initial begin
        #4000000;
        nerr++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m_pc = 16'h0; m_pg = 8'h0; m_sp = 8'h07;
        chk_state("R11");
        chk("R11", "busy", {31'h0, busy}, 0);

        // R10: indexed address wraps inside the current page
        dptr = 16'hFFF0; acc = 8'h20; #1;
        chk("R10", "code_addr wrap", {8'h0, code_addr}, 32'h0000_0010);

        t_ljmp(16'h1234, 8'h05);

        dptr = 16'h1000; acc = 8'hFF; #1;
        chk("R10", "code_addr page", {8'h0, code_addr}, 32'h0005_10FF);
        run(8'h73, 8'h0, 8'h0, 1'b1, 1'b0, 16'h0, n);
        m_pc = 16'h10FF;
        chk("R10", "jind cycles", n, 1);
        chk_state("R10");

        // R3 sweep over all short-call page bits and several low bytes
        for (int h = 0; h < 8; h++) begin
            for (int l = 0; l < 3; l++) begin
                logic [7:0] lo;
                lo = (l == 0) ? 8'h00 : (l == 1) ? 8'h5A : 8'hFF;
                t_acall({h[2:0], lo}, 8'h10 + 8'(h));
                t_ret();
            end
        end

        // R4 long calls across pages, nested then unwound
        for (int i = 0; i < 8; i++) t_lcall(16'h1357 * 16'(i + 1), 8'(i * 33));
        for (int i = 0; i < 8; i++) t_ret();

        // R1 offset rollover keeps the page
        t_ljmp(16'hFFFF, 8'h3C);
        t_step();
        chk_state("R1");
        t_ljmp(16'hFFFE, 8'h3C);
        t_acall(11'h7AB, 8'h09);
        t_ret();
        chk("R1", "return after wrap", {8'h0, pc_full}, 32'h003C_0000);

        // R12 unrelated opcodes and plain steps
        t_ignored(8'hA5);
        t_ignored(8'h01);
        t_ignored(8'h32);
        t_step();
        chk_state("R12");

        // R8 interrupt alone and together with a long call
        t_irq(16'h0033, 1'b0);
        t_ret();
        t_irq(16'h0003, 1'b1);
        t_ret();

        // R9 requests during busy are dropped
        begin
            logic [15:0] ret;
            ret = m_pc + 16'd3;
            ap_page = 8'h44;
            @(posedge clk); #1;
            op_valid = 1'b1; op_b0 = 8'h12; op_b1 = 8'hAB; op_b2 = 8'hCD;
            @(posedge clk); #1;
            op_b0 = 8'h02; op_b1 = 8'h99; op_b2 = 8'h99; irq_req = 1'b1; irq_vec = 16'h7777;
            pc_inc = 1'b1; ap_page = 8'h77;
            n = 1;
            while (busy && n < 40) begin @(posedge clk); #1; n++; end
            op_valid = 1'b0; irq_req = 1'b0; pc_inc = 1'b0;
            chk("R9", "busy cycles", n, 5);
            chk_pushed("R9", ret, m_pg);
            m_pc = 16'hABCD; m_pg = 8'h44;
            chk_state("R9");
            t_ret();
        end

        // R5 stack pointer wraps modulo 256 across deep nesting
        for (int i = 0; i < 90; i++) t_lcall(16'h0101 * 16'(i), 8'(255 - i));
        chk("R5", "sp after wrap", {24'h0, sp_val}, {24'h0, 8'(8'h07 + 8'(270))});
        for (int i = 0; i < 90; i++) t_ret();
        chk("R6", "sp restored", {24'h0, sp_val}, 32'h07);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule